// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four modem handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and folds them into one 8-bit status byte for a host. The upper nibble shows the present level of each line. The lower nibble holds sticky change flags. Clear-to-send, data-set-ready and carrier detect flag any change of level. The ring indicator flags only the trailing edge of a ring, that is the 1-to-0 transition.

A modem-status interrupt is raised whenever the enable is set and any change flag is set. The host reads the byte with a one-cycle read strobe, and that read clears the flags. A change detected on the same clock edge as the read is kept.

External pins pass through a synchroniser before edge detection. A loopback select replaces the pins with the block's own modem-control outputs so that software can test the path without a cable. All lines are active-high: 1 means asserted.

Top module: `modem_change_detect`

## Requirements
- R1: `statusByte` bits 4, 5, 6 and 7 show the current level of CTS, DSR, RI and DCD. An external pin change appears there after SYNC_STAGES+1 rising edges (3 with the default). A loopback source change appears after 1 edge.
- R2: Bit 0 (CTS) and bit 1 (DSR) are set on the edge where the level shown in bit 4 or bit 5 changes in either direction.
- R3: Bit 2 is set only when the level shown in bit 6 (RI) goes from 1 to 0. A 0-to-1 change of RI never sets it.
- R4: Bit 3 is set on the edge where the level shown in bit 7 (DCD) changes in either direction.
- R5: With `rdStrobe` high, `statusByte` is valid in that same cycle. Bits 0 to 3 are cleared on the edge that ends the strobe cycle, except a flag whose change is detected on that same edge, which reads 1 afterwards. Without a read, a set flag stays set.
- R6: `modemInt` is 1 exactly when `modemIntEn` is 1 and any of bits 0 to 3 is 1. The enable acts combinationally.
- R7: With `loopEn` high, the pins are ignored. CTS follows `rtsCtl`, DSR follows `dtrCtl`, RI follows `out1Ctl` and DCD follows `out2Ctl`. A level change caused by switching `loopEn` counts as a change.
- R8: After reset, `statusByte` is 0x00, `modemInt` is 0 and the synchroniser stages hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| ctsPin | input | 1 | External clear-to-send, asynchronous |
| dsrPin | input | 1 | External data-set-ready, asynchronous |
| riPin | input | 1 | External ring indicator, asynchronous |
| dcdPin | input | 1 | External carrier detect, asynchronous |
| loopEn | input | 1 | Loopback select |
| rtsCtl | input | 1 | Internal request-to-send output, loopback source for CTS |
| dtrCtl | input | 1 | Internal terminal-ready output, loopback source for DSR |
| out1Ctl | input | 1 | Internal user output 1, loopback source for RI |
| out2Ctl | input | 1 | Internal user output 2, loopback source for DCD |
| modemIntEn | input | 1 | Modem-status interrupt enable |
| rdStrobe | input | 1 | One-cycle read of the status byte |
| statusByte | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| modemInt | output | 1 | Modem-status interrupt |

## Verification
The assertions take for granted that `loopEn`, the four loopback sources, `rdStrobe` and `modemIntEn` are synchronous to the clock and free of unknown values after reset. Only the four pins may move at arbitrary times.

The stimulus changes every input, pins included, only at the falling edge. Pin toggles, loopback switching, reads and enable changes are drawn at random and mixed with directed cases. Those directed cases are a read coinciding with a detected change, a leading versus a trailing ring edge, and pin activity during loopback. A bench model of the synchroniser latency and the flag rules predicts the byte every cycle.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int LINES = 4;
  localparam int CTS_I = 0;
  localparam int DSR_I = 1;
  localparam int RI_I  = 2;
  localparam int DCD_I = 3;

  typedef struct packed {
    logic [LINES-1:0] setFlag;
    logic             clrFlags;
  } flagCmd_t;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/mstat_ctrl.sv
module mstat_ctrl
  import mstat_pkg::*;
(
  input  logic [LINES-1:0] curVec,
  input  logic [LINES-1:0] prevVec,
  input  logic             rdStrobe,
  output flagCmd_t         cmd
);
  logic [LINES-1:0] setVec;

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (i == RI_I) begin : g_trail
      assign setVec[i] = prevVec[i] & ~curVec[i];
    end else begin : g_any
      assign setVec[i] = prevVec[i] ^ curVec[i];
    end
  end

  always_comb begin
    cmd.setFlag  = setVec;
    cmd.clrFlags = rdStrobe;
  end
endmodule

// File: rtl/mstat_dp.sv
module mstat_dp
  import mstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pinVec,
  input  logic [LINES-1:0] loopVec,
  input  logic             loopEn,
  input  flagCmd_t         cmd,
  output logic [LINES-1:0] curVec,
  output logic [LINES-1:0] prevVec,
  output logic [LINES-1:0] flags
);
  logic [LINES-1:0] syncVec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    mstat_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(pinVec[i]),
      .syncOut(syncVec[i])
    );
  end

  assign curVec = loopEn ? loopVec : syncVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevVec <= '0;
      flags   <= '0;
    end else begin
      prevVec <= curVec;
      flags   <= (flags & ~{LINES{cmd.clrFlags}}) | cmd.setFlag;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !cmd.clrFlags) |=> flags[i]);
    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.clrFlags && !cmd.setFlag[i]) |=> !flags[i]);
    if (i == RI_I) begin : g_ri
      // R3
      ri_trailing_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(flags[i]) |-> ($past(prevVec[i]) && !prevVec[i]));
    end else begin : g_delta
      // R2
      delta_change_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(flags[i]) |-> (prevVec[i] != $past(prevVec[i])));
    end
  end
endmodule

// File: rtl/modem_change_detect.sv
module modem_change_detect
  import mstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsPin,
  input  logic       dsrPin,
  input  logic       riPin,
  input  logic       dcdPin,
  input  logic       loopEn,
  input  logic       rtsCtl,
  input  logic       dtrCtl,
  input  logic       out1Ctl,
  input  logic       out2Ctl,
  input  logic       modemIntEn,
  input  logic       rdStrobe,
  output logic [7:0] statusByte,
  output logic       modemInt
);
  flagCmd_t         cmd;
  logic [LINES-1:0] curVec;
  logic [LINES-1:0] prevVec;
  logic [LINES-1:0] flags;
  logic [LINES-1:0] pinVec;
  logic [LINES-1:0] loopVec;

  assign pinVec  = {dcdPin, riPin, dsrPin, ctsPin};
  assign loopVec = {out2Ctl, out1Ctl, dtrCtl, rtsCtl};

  mstat_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pinVec (pinVec),
    .loopVec(loopVec),
    .loopEn (loopEn),
    .cmd    (cmd),
    .curVec (curVec),
    .prevVec(prevVec),
    .flags  (flags)
  );

  mstat_ctrl u_ctrl (
    .curVec  (curVec),
    .prevVec (prevVec),
    .rdStrobe(rdStrobe),
    .cmd     (cmd)
  );

  assign statusByte = {prevVec, flags};
  assign modemInt   = modemIntEn & (|flags);

  // R6
  int_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modemIntEn |-> !modemInt);
  // R6
  int_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modemInt) |-> (modemIntEn && statusByte[3:0] != 4'h0));
endmodule

// File: tb/tb_modem_change_detect.sv
module tb_modem_change_detect;
  logic clk = 0;
  logic rstN = 0;
  logic ctsPin = 0, dsrPin = 0, riPin = 0, dcdPin = 0;
  logic loopEn = 0, rtsCtl = 0, dtrCtl = 0, out1Ctl = 0, out2Ctl = 0;
  logic modemIntEn = 0, rdStrobe = 0;
  logic [7:0] statusByte;
  logic modemInt;

  int checks = 0, failures = 0;
  logic [3:0] mS1 = 0, mS2 = 0, mPrev = 0, mFlags = 0;

  always #4 clk = ~clk;

  modem_change_detect dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [7:0] e;
    logic eInt;
    e = {mPrev, mFlags};
    eInt = modemIntEn & (|mFlags);
    chk(statusByte[7:4] == e[7:4], "R1 levels", statusByte[7:4], e[7:4]);
    chk(statusByte[1:0] == e[1:0], "R2 cts/dsr flags", statusByte[1:0], e[1:0]);
    chk(statusByte[2] == e[2], "R3 ri trailing flag", statusByte[2], e[2]);
    chk(statusByte[3] == e[3], "R4 dcd flag", statusByte[3], e[3]);
    chk(modemInt == eInt, "R6 interrupt", modemInt, eInt);
  endtask

  task automatic tick();
    logic [3:0] cur, setV;
    @(posedge clk);
    cur = loopEn ? {out2Ctl, out1Ctl, dtrCtl, rtsCtl} : mS2;
    setV = (cur ^ mPrev) & 4'b1011;
    setV[2] = mPrev[2] & ~cur[2];
    mFlags = (mFlags & ~{4{rdStrobe}}) | setV;
    mPrev = cur;
    mS2 = mS1;
    mS1 = {dcdPin, riPin, dsrPin, ctsPin};
    @(negedge clk);
    #1;
    compareAll();
  endtask

  task automatic clearAll();
    rdStrobe = 1; tick(); rdStrobe = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B));
    repeat (4) @(negedge clk);
    chk(statusByte == 8'h00, "R8 reset byte", statusByte, 0);
    chk(modemInt == 1'b0, "R8 reset int", modemInt, 0);
    rstN = 1;
    // R1 latency through synchroniser, R2 flag
    ctsPin = 1;
    tick(); tick();
    chk(statusByte[4] == 1'b0, "R1 not yet visible", statusByte[4], 0);
    tick();
    chk(statusByte[4] == 1'b1, "R1 visible after 3 edges", statusByte[4], 1);
    chk(statusByte[0] == 1'b1, "R2 cts change", statusByte[0], 1);
    // R5 read clears
    clearAll();
    chk(statusByte[3:0] == 4'h0, "R5 cleared by read", statusByte[3:0], 0);
    // R7 loopback, R3 leading vs trailing RI
    loopEn = 1; tick(); clearAll();
    out1Ctl = 1; tick();
    chk(statusByte[6] == 1'b1, "R7 ri follows out1", statusByte[6], 1);
    chk(statusByte[2] == 1'b0, "R3 leading edge ignored", statusByte[2], 0);
    out1Ctl = 0; tick();
    chk(statusByte[2] == 1'b1, "R3 trailing edge sets", statusByte[2], 1);
    // R5 change on the read edge survives
    rtsCtl = 1; rdStrobe = 1; tick(); rdStrobe = 0;
    chk(statusByte[0] == 1'b1, "R5 coincident change kept", statusByte[0], 1);
    chk(statusByte[2] == 1'b0, "R5 other flag cleared", statusByte[2], 0);
    clearAll();
    // R7 pins ignored in loopback
    for (int k = 0; k < 6; k++) begin
      {dcdPin, riPin, dsrPin, ctsPin} = 4'(k * 5 + 3);
      tick();
    end
    chk(statusByte == 8'h10, "R7 pins ignored", statusByte, 8'h10);
    // R4 dcd any change
    out2Ctl = 1; tick();
    chk(statusByte[3] == 1'b1, "R4 dcd rise", statusByte[3], 1);
    clearAll();
    out2Ctl = 0; tick();
    chk(statusByte[3] == 1'b1, "R4 dcd fall", statusByte[3], 1);
    clearAll();
    // R6 enable gating
    modemIntEn = 0; dtrCtl = 1; tick();
    chk(modemInt == 1'b0, "R6 disabled", modemInt, 0);
    modemIntEn = 1; #1;
    chk(modemInt == 1'b1, "R6 enabled", modemInt, 1);
    clearAll();
    chk(modemInt == 1'b0, "R6 drops after read", modemInt, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(3) == 0) {dcdPin, riPin, dsrPin, ctsPin} = 4'($urandom);
      if ($urandom_range(3) == 0) {out2Ctl, out1Ctl, dtrCtl, rtsCtl} = 4'($urandom);
      if ($urandom_range(40) == 0) loopEn = ~loopEn;
      if ($urandom_range(15) == 0) modemIntEn = ~modemIntEn;
      rdStrobe = ($urandom_range(4) == 0);
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule